// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block turns the conditioned level of each general-purpose pin into an interrupt request. Every pin has its own detector. The detector first applies the pin's polarity-invert bit to the level. It then watches the result either for a rising transition or for a high level. Each hit sets a sticky pending flag. The request output of a pin is the pending flag gated by a per-pin enable.

Software reaches each pin through one 64-bit control word on a simple write/read port. In that word, a write with a 1 in a given position performs one action:

| Bit | Action |
|---|---|
| 0 | acknowledge (clear) the pending flag |
| 1 | force the pending flag |
| 2 | clear the enable |
| 3 | set the enable |

Writing 0 to any of these bits does nothing, so one write can mask and acknowledge together. Polarity and detection mode are static configuration inputs that come from the pin's configuration logic. The glitch filter upstream of this block, and message-signalled delivery downstream of it, sit outside the block.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every pending flag and every enable is 0, every request output is low, and every control word reads as zero.
- R2: The control word of pin n sits at byte address 0x800 + 8*n. A write to any other address (below 0x800, not a multiple of 8, or past the last pin) changes nothing. A read of any other address returns zero. A read of a mapped word returns the pending flag in bit 0, the enable in bit 3, and zero in all other bits.
- R3: In edge mode (mode input 1), the pending flag is set on the clock edge where the detected signal is high and was low at the previous edge. The history of the detected signal resets to low. A signal that stays high does not set the flag again after an acknowledge.
- R4: In level mode (mode input 0), the pending flag is set on every edge where the detected signal is high, so an acknowledge has no lasting effect while the level persists.
- R5: The detected signal is the pin level XOR the invert input, so an inverted pin reports low levels and falling transitions.
- R6: With the detect-enable input low, the pin never sets its pending flag, whatever its level.
- R7: Writing 1 to bit 0 clears the pending flag. Writing 1 to bit 1 sets it, even when detection is off.
- R8: If a hardware detection and an acknowledge land on the same edge, the pending flag ends up set.
- R9: Writing 1 to bit 3 sets the enable and writing 1 to bit 2 clears it. If both are 1, clear wins. Bits 2 and 0 together mask and acknowledge in one write.
- R10: The request output is high exactly when both the pending flag and the enable are 1. A flag that becomes pending while masked stays pending and raises the request once unmasked.
- R11: A write to one pin's word never changes another pin's flags or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Byte address for read and write |
| regWrEn | input | 1 | Write strobe, one clock per write |
| regWrData | input | 64 | Write data; only bits 3..0 act |
| regRdData | output | 64 | Combinational read data for regAddr |
| pinLevel | input | NUM_PINS | Filtered level of each pin |
| pinInvert | input | NUM_PINS | Per-pin polarity invert |
| detectEn | input | NUM_PINS | Per-pin hardware detection enable |
| edgeMode | input | NUM_PINS | 1 = edge sensing, 0 = level sensing |
| irqReq | output | NUM_PINS | Per-pin interrupt request |

## Verification
The assertions check several rules on every cycle:
- a high level in level mode, or a fresh rise in edge mode, is followed by a pending flag;
- a pending flag stays set until it is acknowledged;
- an acknowledge with no competing set empties the flag;
- an enable-clear always leaves the enable at 0;
- the address decode never selects two pins at once.

Other rules need stimulus sequences, so only the bench scenarios show them:
- set-beats-acknowledge, and clear-beats-set on the enable;
- the no-retrigger rule of a held edge;
- inverted polarity;
- that unmapped, misaligned and out-of-range writes leave every pin untouched.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int REG_W        = 64;
  localparam int STRIDE_BYTES = 8;
  localparam int ACK_BIT      = 0;
  localparam int SWSET_BIT    = 1;
  localparam int ENCLR_BIT    = 2;
  localparam int ENSET_BIT    = 3;
  localparam int ACT_BITS     = 4;

  // Write strobes the decoder hands to one pin's datapath slice.
  typedef struct packed {
    logic ack;
    logic swSet;
    logic enClr;
    logic enSet;
  } pinStrobe_t;
endpackage

// File: rtl/pin_irq_decode.sv
module pin_irq_decode
  import pin_irq_pkg::*;
#(
  parameter int          NUM_PINS = 4,
  parameter int          ADDR_W   = 16,
  parameter int unsigned REG_BASE = 32'h800
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWrEn,
  input  logic [ACT_BITS-1:0]           wrBits,
  output logic [NUM_PINS-1:0]           pinHit,
  output pinStrobe_t [NUM_PINS-1:0]     strobes
);
  localparam int STRIDE_LOG2 = $clog2(STRIDE_BYTES);
  localparam int IDX_W       = ADDR_W - STRIDE_LOG2;

  logic [ADDR_W-1:0] offset;
  logic              aboveBase;
  logic              aligned;
  logic [IDX_W-1:0]  idx;

  assign offset    = regAddr - ADDR_W'(REG_BASE);
  assign aboveBase = (regAddr >= ADDR_W'(REG_BASE));
  assign aligned   = (offset[STRIDE_LOG2-1:0] == '0);
  assign idx       = offset[ADDR_W-1:STRIDE_LOG2];

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_hit
    assign pinHit[gi]        = aboveBase && aligned && (idx == IDX_W'(gi));
    assign strobes[gi].ack   = regWrEn && pinHit[gi] && wrBits[ACK_BIT];
    assign strobes[gi].swSet = regWrEn && pinHit[gi] && wrBits[SWSET_BIT];
    assign strobes[gi].enClr = regWrEn && pinHit[gi] && wrBits[ENCLR_BIT];
    assign strobes[gi].enSet = regWrEn && pinHit[gi] && wrBits[ENSET_BIT];
  end

  // R2: an address selects at most one pin word
  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pinHit));
endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_PINS-1:0]       pinLevel,
  input  logic [NUM_PINS-1:0]       pinInvert,
  input  logic [NUM_PINS-1:0]       detectEn,
  input  logic [NUM_PINS-1:0]       edgeMode,
  input  pinStrobe_t [NUM_PINS-1:0] strobes,
  input  logic [NUM_PINS-1:0]       pinHit,
  output logic [NUM_PINS-1:0]       irqReq,
  output logic [REG_W-1:0]          regRdData
);
  logic [NUM_PINS-1:0] pendVec;
  logic [NUM_PINS-1:0] enVec;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    logic sigNow;
    logic sigPrev;
    logic hwSet;
    logic pend;
    logic en;

    assign sigNow = pinLevel[gi] ^ pinInvert[gi];
    assign hwSet  = detectEn[gi] && (edgeMode[gi] ? (sigNow && !sigPrev) : sigNow);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sigPrev <= 1'b0;
        pend    <= 1'b0;
        en      <= 1'b0;
      end else begin
        sigPrev <= sigNow;
        if (hwSet || strobes[gi].swSet) pend <= 1'b1;
        else if (strobes[gi].ack)       pend <= 1'b0;
        if (strobes[gi].enClr)          en <= 1'b0;
        else if (strobes[gi].enSet)     en <= 1'b1;
      end
    end

    assign irqReq[gi]  = pend && en;
    assign pendVec[gi] = pend;
    assign enVec[gi]   = en;

    // R4: high level in level mode leaves the flag pending
    assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
      (detectEn[gi] && !edgeMode[gi] && sigNow) |=> pend);
    // R3: a fresh rise in edge mode leaves the flag pending
    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
      (detectEn[gi] && edgeMode[gi] && sigNow && !sigPrev) |=> pend);
    // R7: acknowledge with no competing set empties the flag
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[gi].ack && !strobes[gi].swSet && !detectEn[gi]) |=> !pend);
    // R10: a pending flag is sticky until acknowledged
    assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
      (pend && !strobes[gi].ack) |=> pend);
    // R9: clear of the enable always wins
    assert_en_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
      strobes[gi].enClr |=> !en);
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (pinHit[i]) begin
        regRdData[ACK_BIT]   = pendVec[i];
        regRdData[ENSET_BIT] = enVec[i];
      end
    end
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int          NUM_PINS = 4,
  parameter int          ADDR_W   = 16,
  parameter int unsigned REG_BASE = 32'h800
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic [NUM_PINS-1:0]  pinLevel,
  input  logic [NUM_PINS-1:0]  pinInvert,
  input  logic [NUM_PINS-1:0]  detectEn,
  input  logic [NUM_PINS-1:0]  edgeMode,
  output logic [NUM_PINS-1:0]  irqReq
);
  pinStrobe_t [NUM_PINS-1:0] strobes;
  logic [NUM_PINS-1:0]       pinHit;
  logic                      unusedWrBits;

  assign unusedWrBits = ^regWrData[REG_W-1:ACT_BITS];

  pin_irq_decode #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .REG_BASE (REG_BASE)
  ) u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .wrBits  (regWrData[ACT_BITS-1:0]),
    .pinHit  (pinHit),
    .strobes (strobes)
  );

  pin_irq_datapath #(
    .NUM_PINS (NUM_PINS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .pinLevel  (pinLevel),
    .pinInvert (pinInvert),
    .detectEn  (detectEn),
    .edgeMode  (edgeMode),
    .strobes   (strobes),
    .pinHit    (pinHit),
    .irqReq    (irqReq),
    .regRdData (regRdData)
  );
endmodule

// File: tb/pin_irq_detect_bench.sv
module pin_irq_detect_bench;
  localparam int NP = 4;
  localparam int AW = 16;

  typedef struct packed {
    logic [3:0] lvl;
    logic [3:0] inv;
    logic [3:0] det;
    logic [3:0] edg;
    logic       we;
    logic [1:0] pin;
    logic [3:0] wd;
    logic [3:0] expIrq;
    logic       expPend;
    logic       expEn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 4'b0000, 4'b0001, 4'b0001, 1'b1, 2'd0, 4'b1000, 4'b0000, 1'b0, 1'b1, 4'd9},
    '{4'b0001, 4'b0000, 4'b0001, 4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b1, 1'b1, 4'd3},
    '{4'b0001, 4'b0000, 4'b0001, 4'b0001, 1'b1, 2'd0, 4'b0001, 4'b0000, 1'b0, 1'b1, 4'd3},
    '{4'b0000, 4'b0000, 4'b0001, 4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0, 1'b1, 4'd3},
    '{4'b0001, 4'b0000, 4'b0001, 4'b0001, 1'b1, 2'd0, 4'b0001, 4'b0001, 1'b1, 1'b1, 4'd8},
    '{4'b0001, 4'b0000, 4'b0001, 4'b0001, 1'b1, 2'd0, 4'b0101, 4'b0000, 1'b0, 1'b0, 4'd9},
    '{4'b0000, 4'b0000, 4'b0001, 4'b0001, 1'b1, 2'd0, 4'b0010, 4'b0000, 1'b1, 1'b0, 4'd10},
    '{4'b0000, 4'b0000, 4'b0001, 4'b0001, 1'b1, 2'd0, 4'b1000, 4'b0001, 1'b1, 1'b1, 4'd10},
    '{4'b0000, 4'b0000, 4'b0001, 4'b0001, 1'b1, 2'd0, 4'b1100, 4'b0000, 1'b1, 1'b0, 4'd9},
    '{4'b0000, 4'b0000, 4'b0001, 4'b0001, 1'b1, 2'd0, 4'b0001, 4'b0000, 1'b0, 1'b0, 4'd7},
    '{4'b0010, 4'b0010, 4'b0011, 4'b0001, 1'b1, 2'd1, 4'b1000, 4'b0000, 1'b0, 1'b1, 4'd5},
    '{4'b0000, 4'b0010, 4'b0011, 4'b0001, 1'b0, 2'd1, 4'b0000, 4'b0010, 1'b1, 1'b1, 4'd4},
    '{4'b0000, 4'b0010, 4'b0011, 4'b0001, 1'b1, 2'd1, 4'b0001, 4'b0010, 1'b1, 1'b1, 4'd4},
    '{4'b0010, 4'b0010, 4'b0011, 4'b0001, 1'b1, 2'd1, 4'b0001, 4'b0000, 1'b0, 1'b1, 4'd4},
    '{4'b0000, 4'b0010, 4'b0001, 4'b0001, 1'b0, 2'd1, 4'b0000, 4'b0000, 1'b0, 1'b1, 4'd6},
    '{4'b0010, 4'b0010, 4'b0001, 4'b0001, 1'b1, 2'd2, 4'b1010, 4'b0100, 1'b1, 1'b1, 4'd7},
    '{4'b0010, 4'b0010, 4'b0001, 4'b0001, 1'b1, 2'd3, 4'b0001, 4'b0100, 1'b0, 1'b0, 4'd11}
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [AW-1:0]  regAddr = '0;
  logic           regWrEn = 1'b0;
  logic [63:0]    regWrData = '0;
  logic [63:0]    regRdData;
  logic [NP-1:0]  pinLevel = '0;
  logic [NP-1:0]  pinInvert = '0;
  logic [NP-1:0]  detectEn = '0;
  logic [NP-1:0]  edgeMode = '0;
  logic [NP-1:0]  irqReq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pin_irq_detect #(.NUM_PINS(NP), .ADDR_W(AW)) u_pin_irq_detect (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .pinLevel  (pinLevel),
    .pinInvert (pinInvert),
    .detectEn  (detectEn),
    .edgeMode  (edgeMode),
    .irqReq    (irqReq)
  );

  function automatic string tagName(input logic [3:0] r);
    case (r)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [63:0] word(input logic pend, input logic en);
    return {60'd0, en, 2'b00, pend};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge: one write (or idle) cycle, returns at the next negedge.
  task automatic cycle(input logic [AW-1:0] addr, input logic we, input logic [3:0] wd);
    regAddr   = addr;
    regWrEn   = we;
    regWrData = {60'hFFFF_FFFF_FFFF_FFF, wd};
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readWord(input logic [AW-1:0] addr, output logic [63:0] val);
    regAddr = addr;
    #1;
    val = regRdData;
  endtask

  logic [63:0] rd;

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #5;
    // R1: reset state
    check("R1", {60'd0, irqReq}, 64'd0);
    for (int p = 0; p < NP; p++) begin
      readWord(AW'(16'h800 + 8 * p), rd);
      check("R1", rd, 64'd0);
    end
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      pinLevel  = VECS[k].lvl;
      pinInvert = VECS[k].inv;
      detectEn  = VECS[k].det;
      edgeMode  = VECS[k].edg;
      cycle(AW'(16'h800 + 8 * VECS[k].pin), VECS[k].we, VECS[k].wd);
      check(tagName(VECS[k].req), {60'd0, irqReq}, {60'd0, VECS[k].expIrq});
      check(tagName(VECS[k].req), regRdData, word(VECS[k].expPend, VECS[k].expEn));
    end

    // R2: misaligned write near pin 2 must not acknowledge it
    cycle(16'h814, 1'b1, 4'b0001);
    check("R2", {60'd0, irqReq}, 64'h4);
    check("R2", regRdData, 64'd0);
    // R2: write past the last pin and below the base
    cycle(16'h820, 1'b1, 4'b1010);
    check("R2", regRdData, 64'd0);
    cycle(16'h7F8, 1'b1, 4'b1010);
    check("R2", regRdData, 64'd0);
    readWord(16'h818, rd);
    check("R2", rd, 64'd0);
    readWord(16'h800, rd);
    check("R2", rd, 64'd0);
    readWord(16'h810, rd);
    check("R11", rd, word(1'b1, 1'b1));
    check("R2", {60'd0, irqReq}, 64'h4);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1", {60'd0, irqReq}, 64'd0);
    readWord(16'h810, rd);
    check("R1", rd, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R5: inverted edge on pin 3 reports a falling transition
    pinLevel  = 4'b1000;
    pinInvert = 4'b1000;
    detectEn  = 4'b1000;
    edgeMode  = 4'b1000;
    cycle(16'h818, 1'b1, 4'b1000);
    check("R5", {60'd0, irqReq}, 64'd0);
    check("R5", regRdData, word(1'b0, 1'b1));
    pinLevel = 4'b0000;
    cycle(16'h818, 1'b0, 4'b0000);
    check("R5", {60'd0, irqReq}, 64'h8);
    check("R5", regRdData, word(1'b1, 1'b1));
    // R3: held inverted level, acknowledge sticks
    cycle(16'h818, 1'b1, 4'b0001);
    check("R3", regRdData, word(1'b0, 1'b1));
    cycle(16'h818, 1'b0, 4'b0000);
    check("R3", {60'd0, irqReq}, 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule